// File: doc/BRIEF.md
# Fault and Auto-Restart Supervisor

This block decides, cycle by cycle, whether the primary power switch may conduct. It watches digitised comparator flags for the bypass supply, the input line, a bypass overcurrent used for overvoltage sensing, and die temperature. It also watches the stream of switching-cycle requests arriving from the secondary side. When a fault appears it drops the switch enable in the same clock cycle. It then steps into a recovery state. Depending on the fault, that state is a supply wait, a timed auto-restart pause, a thermal cool-down or a sticky latch.

A static configuration input selects the policy for the overcurrent, over-temperature and overload faults: latch-off or non-latching recovery. A lost request stream always leads to auto-restart, so that communication can come back. Every time limit is a parameter in clock cycles.

States and transitions. There are six states: `ST_UV`, `ST_RUN`, `ST_AR_OVL`, `ST_AR_NOCOMM`, `ST_OTP` and `ST_LATCH`. Reset enters `ST_UV`.
- UV-to-RUN: taken when the supply reaches shunt level.
- RUN-to-AR_OVL: taken on overcurrent or overload when non-latching.
- RUN-to-AR_NOCOMM: taken on request timeout.
- RUN-to-OTP: taken on over-temperature when non-latching.
- RUN-to-UV: taken on supply undervoltage.
- any-to-LATCH: taken on overcurrent or over-temperature, or on overload while in RUN, when latching.
- AR-to-RUN: taken when the off-time expires.
- OTP-to-RUN: taken when the cooled flag is seen.
- LATCH-to-UV: taken on a deep supply drop or line undervoltage.

Top module: `fault_restart_sup`

## Requirements
- R1: After reset the block is in the supply-wait state with `sw_en` low. `status` uses 0=OK, 1=UV, 2=OVERLOAD_AR, 3=NOCOMM_AR, 4=OTP, 5=LATCHED, and reads 1 here. One cycle after `bp_shunt` is seen high, `status` is 0 and `sw_en` is 1.
- R2: In the supply-wait state, `bp_uv` going low while `bp_shunt` stays low leaves `status` at 1 and `sw_en` low.
- R3: `sw_en` is low in the very cycle in which `bp_uv`, `bp_ocp` or `otp_hot` is high. `bp_uv` alone in the running state leads to `status` 1 on the next cycle.
- R4: A request interval is fast when it is shorter than `OVL_PERIOD` cycles. Fast requests sustained for `OVL_HOLD` cycles cause an overload: `status` becomes 2, or 5 when `latch_mode` is 1. Any interval of `OVL_PERIOD` cycles or more restarts the accumulation.
- R5: `SKIP_TIMEOUT` consecutive running cycles without a request give `status` 3, whatever the value of `latch_mode`.
- R6: An auto-restart state (status 2 or 3) holds `sw_en` low for exactly `AR_OFF_TIME` cycles and then returns to status 0.
- R7: `bp_ocp` in the running state gives `status` 5 when `latch_mode` is 1, and `status` 2 when it is 0.
- R8: `otp_hot` with `latch_mode` 0 gives `status` 4 with `sw_en` low until `otp_cool` is high, then status 0 on the next cycle.
- R9: `otp_hot` with `latch_mode` 1 gives `status` 5.
- R10: The latched state (status 5) ignores `bp_shunt` and `otp_cool`. It leaves only on `bp_reset` or `line_uv`, and moves to status 1 on the next cycle.
- R11: A latching event (`latch_mode` 1 with `bp_ocp` or `otp_hot`) during an auto-restart pause moves to status 5 on the next cycle, without waiting for the timer.
- R12: When several faults arrive together in the running state, the priority is `bp_ocp` first, then `otp_hot`, then `bp_uv`, then overload, then request timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-cycle switching request from the secondary |
| bp_uv | input | 1 | Bypass supply below undervoltage threshold |
| bp_shunt | input | 1 | Bypass supply at shunt level |
| bp_reset | input | 1 | Bypass supply below latch-reset level |
| line_uv | input | 1 | Line undervoltage |
| bp_ocp | input | 1 | Bypass overcurrent (overvoltage sense) |
| otp_hot | input | 1 | Die over-temperature |
| otp_cool | input | 1 | Die cooled by hysteresis amount |
| latch_mode | input | 1 | 1 = latch-off policy, 0 = non-latching |
| sw_en | output | 1 | Power switch enable |
| status | output | 3 | Fault status code |

## Verification
A wrong state register shows on `status` at the next clock edge, because the code is decoded directly from the state. A missed fault gate shows on `sw_en` in the same cycle as the offending flag. A wrong auto-restart counter shows as a return to status 0 that comes one or more cycles early or late, so the bench samples the exact exit cycle. A rate or timeout accumulator that fails to clear stays hidden until it trips too early. The mixed-interval and timeout windows are therefore checked over many cycles, with `sw_en` watched on every cycle.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_UV        = 3'd1,
        ST_AR_OVL    = 3'd2,
        ST_AR_NOCOMM = 3'd3,
        ST_OTP       = 3'd4,
        ST_LATCH     = 3'd5
    } fsup_state_t;

    localparam logic [2:0] STAT_OK        = 3'd0;
    localparam logic [2:0] STAT_UV        = 3'd1;
    localparam logic [2:0] STAT_OVL_AR    = 3'd2;
    localparam logic [2:0] STAT_NOCOMM_AR = 3'd3;
    localparam logic [2:0] STAT_OTP       = 3'd4;
    localparam logic [2:0] STAT_LATCHED   = 3'd5;

endpackage

// File: rtl/fsup_rate_mon.sv
module fsup_rate_mon #(
    parameter int PERIOD = 909,
    parameter int HOLD   = 8200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic req,
    output logic trip
);
    localparam int GW = $clog2(PERIOD + 1);
    localparam int HW = $clog2(HOLD + 1);

    logic [GW-1:0] gap_q;
    logic [HW-1:0] hold_q;
    logic          streak_q;
    logic          fast;
    logic [HW-1:0] hold_inc;

    assign fast     = req && (gap_q < GW'(PERIOD));
    assign hold_inc = (hold_q < HW'(HOLD)) ? hold_q + HW'(1) : hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q    <= GW'(PERIOD);
            streak_q <= 1'b0;
            hold_q   <= '0;
        end else if (!run) begin
            gap_q    <= GW'(PERIOD);
            streak_q <= 1'b0;
            hold_q   <= '0;
        end else begin
            if (req)
                gap_q <= GW'(1);
            else if (gap_q < GW'(PERIOD))
                gap_q <= gap_q + GW'(1);

            if (req) begin
                streak_q <= fast;
                hold_q   <= fast ? hold_inc : '0;
            end else if (gap_q >= GW'(PERIOD)) begin
                streak_q <= 1'b0;
                hold_q   <= '0;
            end else if (streak_q) begin
                hold_q <= hold_inc;
            end
        end
    end

    assign trip = run && (hold_q >= HW'(HOLD));

    // R4: a slow interval wipes the accumulated overload time
    a_r4_slow_interval_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (run && req && !fast) |=> (hold_q == '0));

    // R4: the interval counter never passes its saturation point
    a_r4_gap_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= GW'(PERIOD));

endmodule

// File: rtl/fsup_idle_mon.sv
module fsup_idle_mon #(
    parameter int TIMEOUT = 80000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic req,
    output logic trip
);
    localparam int CW = $clog2(TIMEOUT + 1);

    logic [CW-1:0] quiet_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            quiet_q <= '0;
        else if (!run || req)
            quiet_q <= '0;
        else if (quiet_q < CW'(TIMEOUT - 1))
            quiet_q <= quiet_q + CW'(1);
    end

    assign trip = run && !req && (quiet_q == CW'(TIMEOUT - 1));

    // R5: any request restarts the silence count
    a_r5_request_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (run && req) |=> (quiet_q == '0));

endmodule

// File: rtl/fsup_offtimer.sv
module fsup_offtimer #(
    parameter int OFF_TIME = 200000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(OFF_TIME + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (cnt_q < CW'(OFF_TIME - 1))
            cnt_q <= cnt_q + CW'(1);
    end

    assign expired = run && (cnt_q == CW'(OFF_TIME - 1));

    // R6: off-time counter stays inside its window
    a_r6_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(OFF_TIME));

    // R6: an idle timer is always at zero
    a_r6_idle_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0) || run);

endmodule

// File: rtl/fault_restart_sup.sv
module fault_restart_sup
    import fsup_pkg::*;
#(
    parameter int OVL_PERIOD   = 909,
    parameter int OVL_HOLD     = 8200000,
    parameter int SKIP_TIMEOUT = 80000000,
    parameter int AR_OFF_TIME  = 200000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       bp_uv,
    input  logic       bp_shunt,
    input  logic       bp_reset,
    input  logic       line_uv,
    input  logic       bp_ocp,
    input  logic       otp_hot,
    input  logic       otp_cool,
    input  logic       latch_mode,
    output logic       sw_en,
    output logic [2:0] status
);
    fsup_state_t state_q, state_d;

    logic running;
    logic ar_active;
    logic ovl_trip;
    logic idle_trip;
    logic off_done;
    logic latch_evt;
    logic latch_clr;

    assign running   = (state_q == ST_RUN);
    assign ar_active = (state_q == ST_AR_OVL) || (state_q == ST_AR_NOCOMM);
    assign latch_evt = latch_mode && (bp_ocp || otp_hot);
    assign latch_clr = bp_reset || line_uv;

    fsup_rate_mon #(
        .PERIOD (OVL_PERIOD),
        .HOLD   (OVL_HOLD)
    ) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .req   (req),
        .trip  (ovl_trip)
    );

    fsup_idle_mon #(
        .TIMEOUT (SKIP_TIMEOUT)
    ) u_idle (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .req   (req),
        .trip  (idle_trip)
    );

    fsup_offtimer #(
        .OFF_TIME (AR_OFF_TIME)
    ) u_off (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ar_active),
        .expired (off_done)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (bp_ocp)
                    state_d = latch_mode ? ST_LATCH : ST_AR_OVL;
                else if (otp_hot)
                    state_d = latch_mode ? ST_LATCH : ST_OTP;
                else if (bp_uv)
                    state_d = ST_UV;
                else if (ovl_trip)
                    state_d = latch_mode ? ST_LATCH : ST_AR_OVL;
                else if (idle_trip)
                    state_d = ST_AR_NOCOMM;
            end
            ST_UV: begin
                if (latch_evt)
                    state_d = ST_LATCH;
                else if (bp_shunt)
                    state_d = ST_RUN;
            end
            ST_AR_OVL, ST_AR_NOCOMM: begin
                if (latch_evt)
                    state_d = ST_LATCH;
                else if (off_done)
                    state_d = ST_RUN;
            end
            ST_OTP: begin
                if (latch_evt)
                    state_d = ST_LATCH;
                else if (otp_cool)
                    state_d = ST_RUN;
            end
            ST_LATCH: begin
                if (latch_clr)
                    state_d = ST_UV;
            end
            default: state_d = ST_UV;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_UV;
        else
            state_q <= state_d;
    end

    // outputs
    always_comb begin
        sw_en = running && !(bp_ocp || otp_hot || bp_uv || ovl_trip || idle_trip);
        unique case (state_q)
            ST_RUN:       status = STAT_OK;
            ST_UV:        status = STAT_UV;
            ST_AR_OVL:    status = STAT_OVL_AR;
            ST_AR_NOCOMM: status = STAT_NOCOMM_AR;
            ST_OTP:       status = STAT_OTP;
            ST_LATCH:     status = STAT_LATCHED;
            default:      status = STAT_UV;
        endcase
    end

    // R3: a live fault flag always blocks the switch
    a_r3_fault_blocks_switch: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_uv || bp_ocp || otp_hot) |-> !sw_en);

    // R2: supply wait holds until shunt level
    a_r2_uv_waits_for_shunt: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UV && !bp_shunt && !latch_evt) |=> (state_q == ST_UV));

    // R10: latch is sticky without a clear condition
    a_r10_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCH && !latch_clr) |=> (state_q == ST_LATCH));

    // R10: a clear condition sends the latch to supply wait
    a_r10_latch_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCH && latch_clr) |=> (state_q == ST_UV));

    // R11: latching beats a running restart timer
    a_r11_latch_over_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_active && latch_evt) |=> (state_q == ST_LATCH));

    // R6: expiry of the off-time resumes operation
    a_r6_expiry_resumes: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_active && off_done && !latch_evt) |=> (state_q == ST_RUN));

    // R8: thermal hold until cooled
    a_r8_otp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OTP && !otp_cool && !latch_evt) |=> (state_q == ST_OTP));

endmodule

// File: tb/test_fault_restart_sup.sv
module test_fault_restart_sup;

    localparam int P_OVL    = 8;
    localparam int P_HOLD   = 40;
    localparam int P_SKIP   = 30;
    localparam int P_AROFF  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic bp_uv = 1'b1, bp_shunt = 1'b0, bp_reset = 1'b0, line_uv = 1'b0;
    logic bp_ocp = 1'b0, otp_hot = 1'b0, otp_cool = 1'b0, latch_mode = 1'b0;
    logic       sw_en;
    logic [2:0] status;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit req_on  = 1'b0;
    int req_gap = 12;
    int req_cnt = 0;

    always #4 clk = ~clk;

    fault_restart_sup #(
        .OVL_PERIOD   (P_OVL),
        .OVL_HOLD     (P_HOLD),
        .SKIP_TIMEOUT (P_SKIP),
        .AR_OFF_TIME  (P_AROFF)
    ) i_fault_restart_sup (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .bp_uv      (bp_uv),
        .bp_shunt   (bp_shunt),
        .bp_reset   (bp_reset),
        .line_uv    (line_uv),
        .bp_ocp     (bp_ocp),
        .otp_hot    (otp_hot),
        .otp_cool   (otp_cool),
        .latch_mode (latch_mode),
        .sw_en      (sw_en),
        .status     (status)
    );

    // request generator, driven on the falling edge
    always @(negedge clk) begin
        if (!req_on) begin
            req     <= 1'b0;
            req_cnt <= 0;
        end else if (req_cnt >= req_gap - 1) begin
            req     <= 1'b1;
            req_cnt <= 0;
        end else begin
            req     <= 1'b0;
            req_cnt <= req_cnt + 1;
        end
    end

    // {latch_mode, bp_ocp, otp_hot, bp_uv, expected status}
    localparam int NVEC = 9;
    localparam logic [6:0] VEC [NVEC] = '{
        {4'b0100, 3'd2},   // R7 overcurrent, non-latching
        {4'b1100, 3'd5},   // R7 overcurrent, latching
        {4'b0010, 3'd4},   // R8 thermal, hysteretic
        {4'b1010, 3'd5},   // R9 thermal, latching
        {4'b0001, 3'd1},   // R3 supply undervoltage
        {4'b1001, 3'd1},   // R3 undervoltage is never latched
        {4'b0101, 3'd2},   // R12 overcurrent before undervoltage
        {4'b0110, 3'd2},   // R12 overcurrent before thermal
        {4'b1011, 3'd5}    // R12 thermal before undervoltage
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic recover();
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (status == 3'd0) break;
            bp_shunt = 1'b1;
            otp_cool = 1'b1;
            bp_reset = (status == 3'd5);
        end
        bp_shunt = 1'b0;
        otp_cool = 1'b0;
        bp_reset = 1'b0;
        chk("recover to OK", status, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int n;
        int bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset status", status, 1);
        chk("R1 reset sw_en", sw_en, 0);

        // R2: supply recovers past UV but not to shunt
        bp_uv = 1'b0;
        repeat (8) @(negedge clk);
        chk("R2 stays in UV", status, 1);
        chk("R2 switch off", sw_en, 0);

        // R1: shunt level releases
        req_on = 1'b1;
        bp_shunt = 1'b1;
        @(negedge clk);
        bp_shunt = 1'b0;
        chk("R1 run status", status, 0);
        chk("R1 run sw_en", sw_en, 1);

        // table of single-cycle fault vectors
        for (int v = 0; v < NVEC; v++) begin
            latch_mode = VEC[v][6];
            bp_ocp     = VEC[v][5];
            otp_hot    = VEC[v][4];
            bp_uv      = VEC[v][3];
            #1;
            chk("R3 same-cycle disable", sw_en, 0);
            @(negedge clk);
            chk("R7/R8/R9/R12 vector status", status, VEC[v][2:0]);
            bp_ocp = 1'b0; otp_hot = 1'b0; bp_uv = 1'b0; latch_mode = 1'b0;
            recover();
        end

        // R6: exact off-time
        bp_ocp = 1'b1;
        @(negedge clk);
        bp_ocp = 1'b0;
        chk("R6 enter restart", status, 2);
        repeat (P_AROFF - 1) @(negedge clk);
        chk("R6 last off cycle status", status, 2);
        chk("R6 last off cycle sw_en", sw_en, 0);
        @(negedge clk);
        chk("R6 resume status", status, 0);
        chk("R6 resume sw_en", sw_en, 1);

        // R8: thermal hold and release
        otp_hot = 1'b1;
        @(negedge clk);
        otp_hot = 1'b0;
        repeat (8) @(negedge clk);
        chk("R8 hold status", status, 4);
        chk("R8 hold sw_en", sw_en, 0);
        otp_cool = 1'b1;
        @(negedge clk);
        otp_cool = 1'b0;
        chk("R8 cooled", status, 0);

        // R5: lost requests, latch mode does not matter
        latch_mode = 1'b1;
        req_on = 1'b0;
        repeat (15) @(negedge clk);
        chk("R5 no early timeout", sw_en, 1);
        for (int i = 0; i < 25; i++) begin
            if (status != 3'd0) break;
            @(negedge clk);
        end
        chk("R5 timeout status", status, 3);
        latch_mode = 1'b0;
        req_on = 1'b1;
        recover();

        // R4: intervals equal to the period never accumulate
        req_gap = P_OVL;
        bad = 0;
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            if (sw_en !== 1'b1) bad++;
        end
        chk("R4 period-length intervals ignored", bad, 0);

        // R4: fast bursts broken by a slow interval
        bad = 0;
        for (int r = 0; r < 4; r++) begin
            req_gap = 4;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (sw_en !== 1'b1) bad++;
            end
            req_gap = 10;
            for (int i = 0; i < 14; i++) begin
                @(negedge clk);
                if (sw_en !== 1'b1) bad++;
            end
        end
        chk("R4 slow interval restarts accumulation", bad, 0);

        // R4: sustained overload, non-latching
        req_gap = 12;
        repeat (20) @(negedge clk);
        req_gap = 4;
        n = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (status != 3'd0) break;
            n++;
        end
        chk("R4 overload restart", status, 2);
        chk("R4 overload not early", int'(n >= 30), 1);
        req_gap = 12;
        recover();

        // R4: sustained overload, latching
        latch_mode = 1'b1;
        req_gap = 4;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (status != 3'd0) break;
        end
        chk("R4 overload latch", status, 5);
        req_gap = 12;
        latch_mode = 1'b0;
        recover();

        // R10: latch ignores shunt and cooled, clears on line UV
        latch_mode = 1'b1;
        bp_ocp = 1'b1;
        @(negedge clk);
        bp_ocp = 1'b0;
        bp_shunt = 1'b1;
        otp_cool = 1'b1;
        repeat (10) @(negedge clk);
        chk("R10 latch sticky", status, 5);
        chk("R10 latch sw_en", sw_en, 0);
        line_uv = 1'b1;
        @(negedge clk);
        line_uv = 1'b0;
        chk("R10 line UV clears to UV", status, 1);
        bp_shunt = 1'b0;
        otp_cool = 1'b0;
        latch_mode = 1'b0;
        recover();

        // R11: latching event during restart pause
        bp_ocp = 1'b1;
        @(negedge clk);
        bp_ocp = 1'b0;
        repeat (5) @(negedge clk);
        chk("R11 in restart", status, 2);
        latch_mode = 1'b1;
        otp_hot = 1'b1;
        @(negedge clk);
        otp_hot = 1'b0;
        latch_mode = 1'b0;
        chk("R11 latch wins", status, 5);
        chk("R11 sw_en off", sw_en, 0);
        recover();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule